// File: doc/BRIEF.md
# Keyed Write-Protect and Security Lock Controller

This block sits beside a crypto engine's register file. It guards that file against stray writes and reacts to security events. Software arms three protection enables through a mode register: one for configuration registers, one for interrupt registers and one for control registers. The enables change only when the write carries the 24-bit key 0x414553. Any write to a protected register region is refused. The refused write raises a write-violation event, and the block records the offending register index.

Five event sources are gathered into sticky status flags:

- key-bus violation
- write violation
- clock glitch
- sequence error
- software-control error

A 3-bit policy field decides which group of sources locks the engine, and whether the stored key is wiped as well. While the engine is locked, new start requests are refused. An operation already running is left to finish. The lock is released only by an unlock command, and only after its source flags have been cleared.

Violation sources and software-error types are captured in one of two modes. In first-error mode the first value of a series is kept. Otherwise the latest value is kept. A security interrupt flags the first error of each series.

Top module: `sec_guard`

## Requirements
- R1: The protection enables (bit 0 configuration, bit 1 interrupt, bit 2 control of the mode register at index 0) change on a mode write only when write data bits 31:8 equal 0x414553. A mismatching key leaves them unchanged. Bits 31:8 always read as zero, and all mode fields reset to zero.
- R2: The policy field (bits 7:5) and the first-error enable (bit 4) are written on every mode write, whatever the key.
- R3: The register regions are selected by address bits 3:2: 01 is configuration, 10 is interrupt and 11 is control. A write to a region whose enable is set keeps `fwd_we` low and sets write-violation flag bit 1, with the index at status bits 11:8. A write to an unprotected region raises `fwd_we` in the same cycle.
- R4: With policy 0, events only set their flags (bit 0 key-bus, 2 glitch, 3 sequence, 4 software error). `locked` stays low.
- R5: Policies 1 and 4 lock on key-bus, write-violation and software-error events. Policies 2 and 5 lock on glitch and sequence events. Policies 3 and 6 lock on all five sources. Policy 7 never locks.
- R6: `locked` rises on the clock edge that samples a triggering event. While it is high, `start_grant` stays low even when `start_req` is high.
- R7: Under policies 4, 5 and 6, `key_clear` pulses for exactly the cycle in which `locked` first goes high. Other policies never pulse it.
- R8: An unlock command (command register index 2, bit 0) clears `locked` only when no flag of the selected group is set. A triggering event in the same cycle as the unlock keeps the block locked.
- R9: With first-error enabled, the violation index and the software-error type (status bits 14:12) keep their first value of a series. Otherwise the latest value is kept.
- R10: A status read (index 1) clears every flag except the sequence flag, and clears the captured codes. `sec_irq` rises on an event that arrives when no flag is pending, and is cleared by the status read.
- R11: The sequence flag is cleared only by a soft reset (command bit 1) that follows a status read taken while the flag was set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the block's own registers |
| fwd_we | output | 1 | Write enable passed on to the engine registers |
| ev_keybus | input | 1 | Key-bus violation pulse |
| ev_glitch | input | 1 | Clock-glitch detect pulse |
| ev_seq | input | 1 | Sequence-error pulse |
| ev_swe | input | 1 | Software-control error pulse |
| swe_type | input | 3 | Error type that accompanies `ev_swe` |
| start_req | input | 1 | Request to start a new operation |
| start_grant | output | 1 | Start request allowed through |
| locked | output | 1 | Engine lock level |
| key_clear | output | 1 | One-cycle pulse that wipes the stored key |
| sec_irq | output | 1 | Security-error interrupt flag |

## Verification
An unlock command and a fresh triggering event can land in the same cycle. The bench provokes this by driving a key-bus pulse during the very bus cycle that writes the unlock bit, after the earlier lock source has been cleared. The block passes only if `locked` stays high after that edge, and a later status read followed by a plain unlock then releases it. A status read that coincides with a new event is settled in the same way: the event's flag survives the read.

// File: rtl/sec_guard_pkg.sv
// Shared types and helpers for the write-protect / security lock controller.
// Assumes five event sources in a fixed bit order used by status and policy masks.
package sec_guard_pkg;

    localparam int EV_N      = 5;
    localparam int EV_KEYBUS = 0;
    localparam int EV_WPV    = 1;
    localparam int EV_GLITCH = 2;
    localparam int EV_SEQ    = 3;
    localparam int EV_SWE    = 4;

    typedef struct packed {
        logic [2:0] policy;
        logic       first_err;
        logic       prot_ctrl;
        logic       prot_irq;
        logic       prot_cfg;
    } mode_t;

    // Event sources that a given policy value reacts to.
    function automatic logic [EV_N-1:0] policy_group(input logic [2:0] pol);
        logic [EV_N-1:0] grp_a;
        logic [EV_N-1:0] grp_b;
        grp_a = '0;
        grp_b = '0;
        grp_a[EV_KEYBUS] = 1'b1;
        grp_a[EV_WPV]    = 1'b1;
        grp_a[EV_SWE]    = 1'b1;
        grp_b[EV_GLITCH] = 1'b1;
        grp_b[EV_SEQ]    = 1'b1;
        case (pol)
            3'd1, 3'd4: return grp_a;
            3'd2, 3'd5: return grp_b;
            3'd3, 3'd6: return grp_a | grp_b;
            default:    return '0;
        endcase
    endfunction

endpackage

// File: rtl/sec_guard_wprot.sv
// Mode register plus write filter. Holds the policy, first-error and protection
// enables, and refuses writes to protected register regions.
// Assumes the region is given by the top two address bits, with 00 the block's own registers.
module sec_guard_wprot
    import sec_guard_pkg::*;
#(
    parameter int          ADDR_W = 4,
    parameter int          KEY_W  = 24,
    parameter logic [23:0] KEY    = 24'h414553
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output mode_t             mode,
    output logic              fwd_we,
    output logic              wpv_evt
);

    localparam logic [ADDR_W-1:0] IDX_MODE = '0;
    localparam int                KEY_LSB  = 32 - KEY_W;

    logic [1:0] region;
    logic       mode_wr;
    logic       key_ok;
    logic       blocked;

    assign region  = bus_addr[ADDR_W-1 -: 2];
    assign mode_wr = bus_wr && (bus_addr == IDX_MODE);
    assign key_ok  = (bus_wdata[31:KEY_LSB] == KEY[KEY_W-1:0]);

    // Mode register update: policy and first-error always, enables only with the key.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '0;
        end else if (mode_wr) begin
            mode.policy    <= bus_wdata[7:5];
            mode.first_err <= bus_wdata[4];
            if (key_ok) begin
                mode.prot_ctrl <= bus_wdata[2];
                mode.prot_irq  <= bus_wdata[1];
                mode.prot_cfg  <= bus_wdata[0];
            end
        end
    end

    // Region protection check on incoming engine writes.
    always_comb begin
        case (region)
            2'b01:   blocked = mode.prot_cfg;
            2'b10:   blocked = mode.prot_irq;
            2'b11:   blocked = mode.prot_ctrl;
            default: blocked = 1'b0;
        endcase
    end

    assign wpv_evt = bus_wr && blocked;
    assign fwd_we  = bus_wr && (region != 2'b00) && !blocked;

    assert_badkey_keeps_prot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !key_ok) |=> $stable({mode.prot_ctrl, mode.prot_irq, mode.prot_cfg}));

    assert_policy_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (mode.policy == $past(bus_wdata[7:5])));

endmodule

// File: rtl/sec_guard_evt.sv
// Sticky event flags, violation index / error type capture and the security interrupt.
// Assumes event inputs are single-cycle pulses. A status read clears all but the sequence flag.
module sec_guard_evt
    import sec_guard_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int SWT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EV_N-1:0]   ev_in,
    input  logic [ADDR_W-1:0] wpv_idx_in,
    input  logic [SWT_W-1:0]  swe_type_in,
    input  logic              first_err,
    input  logic              stat_rd,
    input  logic              soft_rst,
    output logic [EV_N-1:0]   flags,
    output logic [ADDR_W-1:0] wpv_idx,
    output logic [SWT_W-1:0]  swe_type,
    output logic              sec_irq
);

    logic [EV_N-1:0] rd_clr;
    logic [EV_N-1:0] flags_kept;
    logic            seq_acked;
    logic            take_wpv;
    logic            take_swe;

    // Flags a status read clears: all except the sequence flag.
    always_comb begin
        rd_clr = '0;
        if (stat_rd) begin
            rd_clr         = '1;
            rd_clr[EV_SEQ] = 1'b0;
        end
        if (soft_rst && seq_acked) begin
            rd_clr[EV_SEQ] = 1'b1;
        end
    end

    assign flags_kept = flags & ~rd_clr;
    assign take_wpv   = ev_in[EV_WPV] && !(first_err && flags_kept[EV_WPV]);
    assign take_swe   = ev_in[EV_SWE] && !(first_err && flags_kept[EV_SWE]);

    // Sticky flags: clear first, then new events win.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= flags_kept | ev_in;
    end

    // Sequence-flag acknowledge: a status read while set arms the soft-reset clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 seq_acked <= 1'b0;
        else if (soft_rst && seq_acked)             seq_acked <= 1'b0;
        else if (stat_rd && flags[EV_SEQ])          seq_acked <= 1'b1;
    end

    // Violation index capture, first or latest of a series.
    always_ff @(posedge clk) begin
        if (!rst_n)        wpv_idx <= '0;
        else if (take_wpv) wpv_idx <= wpv_idx_in;
        else if (stat_rd)  wpv_idx <= '0;
    end

    // Software-error type capture, first or latest of a series.
    always_ff @(posedge clk) begin
        if (!rst_n)        swe_type <= '0;
        else if (take_swe) swe_type <= swe_type_in;
        else if (stat_rd)  swe_type <= '0;
    end

    // Security interrupt: raised at the first error of a series, dropped by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                             sec_irq <= 1'b0;
        else if ((|ev_in) && (flags_kept == '0)) sec_irq <= 1'b1;
        else if (stat_rd)                       sec_irq <= 1'b0;
    end

    assert_wpv_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_in[EV_WPV] |=> flags[EV_WPV]);

    assert_first_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (first_err && flags[EV_WPV] && !stat_rd) |=> $stable(wpv_idx));

    assert_seq_needs_softrst_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[EV_SEQ]) |-> $past(soft_rst));

    assert_irq_on_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec_irq) |-> $past(|ev_in));

endmodule

// File: rtl/sec_guard_lock.sv
// Lock policy: sets the lock on a triggering event, wipes the key for wipe policies,
// and releases on unlock once the group's flags are clear. Events beat unlocks.
module sec_guard_lock
    import sec_guard_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      policy,
    input  logic [EV_N-1:0] ev_in,
    input  logic [EV_N-1:0] flags,
    input  logic            unlock,
    output logic            locked,
    output logic            key_clear
);

    logic [EV_N-1:0] grp;
    logic            trig;
    logic            pending;

    assign grp     = policy_group(policy);
    assign trig    = |(ev_in & grp);
    assign pending = |(flags & grp);

    // Lock level: a trigger sets it, an unlock with no pending source clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                  locked <= 1'b0;
        else if (trig)               locked <= 1'b1;
        else if (unlock && !pending) locked <= 1'b0;
    end

    // Key wipe pulse for the wipe policies, on the edge that first sets the lock.
    always_ff @(posedge clk) begin
        if (!rst_n) key_clear <= 1'b0;
        else        key_clear <= trig && policy[2] && !locked;
    end

    assert_lock_needs_policy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(policy) != 3'd0));

    assert_wipe_with_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        key_clear |-> locked);

    assert_release_by_unlock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(unlock));

endmodule

// File: rtl/sec_guard.sv
// Top of the keyed write-protect and security lock controller. Decodes the block's own
// registers (0 mode, 1 status, 2 command), merges event sources and gates start requests.
// Assumes ADDR_W <= 4 and SWT_W <= 4 so the captured codes fit their status fields.
module sec_guard
    import sec_guard_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int SWT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              fwd_we,
    input  logic              ev_keybus,
    input  logic              ev_glitch,
    input  logic              ev_seq,
    input  logic              ev_swe,
    input  logic [SWT_W-1:0]  swe_type,
    input  logic              start_req,
    output logic              start_grant,
    output logic              locked,
    output logic              key_clear,
    output logic              sec_irq
);

    localparam logic [ADDR_W-1:0] IDX_MODE = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] IDX_STAT = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] IDX_CMD  = ADDR_W'(2);
    localparam int                IDX_LSB  = 8;
    localparam int                SWT_LSB  = 12;

    mode_t             mode;
    logic              wpv_evt;
    logic [EV_N-1:0]   ev_all;
    logic [EV_N-1:0]   flags;
    logic [ADDR_W-1:0] wpv_idx;
    logic [SWT_W-1:0]  swe_type_q;
    logic              stat_rd;
    logic              cmd_wr;
    logic              unlock;
    logic              soft_rst;

    assign stat_rd  = bus_rd && (bus_addr == IDX_STAT);
    assign cmd_wr   = bus_wr && (bus_addr == IDX_CMD);
    assign unlock   = cmd_wr && bus_wdata[0];
    assign soft_rst = cmd_wr && bus_wdata[1];

    // Event vector in the package's bit order.
    always_comb begin
        ev_all             = '0;
        ev_all[EV_KEYBUS]  = ev_keybus;
        ev_all[EV_WPV]     = wpv_evt;
        ev_all[EV_GLITCH]  = ev_glitch;
        ev_all[EV_SEQ]     = ev_seq;
        ev_all[EV_SWE]     = ev_swe;
    end

    sec_guard_wprot #(.ADDR_W(ADDR_W)) u_wprot (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .mode      (mode),
        .fwd_we    (fwd_we),
        .wpv_evt   (wpv_evt)
    );

    sec_guard_evt #(.ADDR_W(ADDR_W), .SWT_W(SWT_W)) u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_in       (ev_all),
        .wpv_idx_in  (bus_addr),
        .swe_type_in (swe_type),
        .first_err   (mode.first_err),
        .stat_rd     (stat_rd),
        .soft_rst    (soft_rst),
        .flags       (flags),
        .wpv_idx     (wpv_idx),
        .swe_type    (swe_type_q),
        .sec_irq     (sec_irq)
    );

    sec_guard_lock u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .policy    (mode.policy),
        .ev_in     (ev_all),
        .flags     (flags),
        .unlock    (unlock),
        .locked    (locked),
        .key_clear (key_clear)
    );

    // Read-data mux for the block's own registers; key bits always read zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == IDX_MODE) begin
            bus_rdata[7:5] = mode.policy;
            bus_rdata[4]   = mode.first_err;
            bus_rdata[2]   = mode.prot_ctrl;
            bus_rdata[1]   = mode.prot_irq;
            bus_rdata[0]   = mode.prot_cfg;
        end else if (bus_addr == IDX_STAT) begin
            bus_rdata[EV_N-1:0]              = flags;
            bus_rdata[IDX_LSB +: ADDR_W]     = wpv_idx;
            bus_rdata[SWT_LSB +: SWT_W]      = swe_type_q;
        end
    end

    assign start_grant = start_req && !locked;

    assert_no_grant_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !start_grant);

endmodule

// File: tb/sec_guard_bench.sv
module sec_guard_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr, bus_rd;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        fwd_we;
    logic        ev_keybus, ev_glitch, ev_seq, ev_swe;
    logic [2:0]  swe_type;
    logic        start_req, start_grant, locked, key_clear, sec_irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] rd_cap;
    logic        we_cap;

    localparam logic [31:0] KEYW = 32'h4145_5300;

    always #4 clk = ~clk;

    sec_guard u_sec_guard (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fwd_we(fwd_we), .ev_keybus(ev_keybus), .ev_glitch(ev_glitch),
        .ev_seq(ev_seq), .ev_swe(ev_swe), .swe_type(swe_type),
        .start_req(start_req), .start_grant(start_grant), .locked(locked),
        .key_clear(key_clear), .sec_irq(sec_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One bus/event cycle: drive just after a falling edge, capture combinational outputs, release.
    task automatic step(input logic wr, input logic rd, input logic [3:0] addr,
                        input logic [31:0] data, input logic [4:0] ev, input logic [2:0] typ);
        bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_wdata = data;
        ev_keybus = ev[0]; ev_glitch = ev[2]; ev_seq = ev[3]; ev_swe = ev[4]; swe_type = typ;
        #2;
        rd_cap = bus_rdata;
        we_cap = fwd_we;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        ev_keybus = 0; ev_glitch = 0; ev_seq = 0; ev_swe = 0; swe_type = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d); step(1, 0, a, d, 5'b0, 3'd0); endtask
    task automatic rd(input logic [3:0] a); step(0, 1, a, 0, 5'b0, 3'd0); endtask
    task automatic ev(input logic [4:0] e, input logic [2:0] t); step(0, 0, 0, 0, e, t); endtask

    task automatic t_reset();
        rd(0); check("R1 mode reset", rd_cap, 0);
        rd(1); check("R10 status reset", rd_cap, 0);
        check("R6 unlocked after reset", {31'd0, locked}, 0);
        start_req = 1; #1;
        check("R6 grant passes request", {31'd0, start_grant}, 1);
        start_req = 0;
        check("R7 no wipe after reset", {31'd0, key_clear}, 0);
    endtask

    task automatic t_key();
        wr(0, 32'h1234_5607);
        rd(0); check("R1 bad key keeps enables", rd_cap, 0);
        wr(0, KEYW | 32'h07);
        rd(0); check("R1 good key sets enables, key reads 0", rd_cap, 32'h07);
        wr(0, 32'h70);
        rd(0); check("R2 policy/first written with bad key", rd_cap, 32'h77);
        wr(0, 32'h00);
        rd(0); check("R2 policy cleared with bad key", rd_cap, 32'h07);
    endtask

    task automatic t_block();
        wr(4, 32'hDEAD);
        check("R3 protected write refused", {31'd0, we_cap}, 0);
        check("R10 irq on first error", {31'd0, sec_irq}, 1);
        check("R4 policy 0 no lock", {31'd0, locked}, 0);
        rd(1); check("R3 violation flag and index", rd_cap, 32'h402);
        check("R10 irq cleared by read", {31'd0, sec_irq}, 0);
        wr(0, KEYW | 32'h06);
        wr(5, 32'h1);
        check("R3 unprotected write forwarded", {31'd0, we_cap}, 1);
        rd(1); check("R3 no violation on allowed write", rd_cap, 0);
    endtask

    task automatic t_report();
        ev(5'b00100, 0);
        check("R4 glitch no lock at policy 0", {31'd0, locked}, 0);
        rd(1); check("R4 glitch flag bit 2", rd_cap, 32'h04);
        rd(1); check("R10 read cleared flags", rd_cap, 0);
    endtask

    task automatic t_group();
        wr(0, 32'h20);
        ev(5'b00100, 0);
        check("R5 policy 1 ignores glitch", {31'd0, locked}, 0);
        rd(1);
        ev(5'b00001, 0);
        check("R5 policy 1 locks on key-bus", {31'd0, locked}, 1);
        check("R7 no wipe at policy 1", {31'd0, key_clear}, 0);
        start_req = 1; #1;
        check("R6 grant blocked while locked", {31'd0, start_grant}, 0);
        start_req = 0;
        wr(2, 32'h1);
        check("R8 unlock refused while flag set", {31'd0, locked}, 1);
        rd(1);
        wr(2, 32'h1);
        check("R8 unlock after clear", {31'd0, locked}, 0);
    endtask

    task automatic t_wipe();
        wr(0, 32'hA0);
        ev(5'b00100, 0);
        check("R7 wipe pulse at policy 5", {31'd0, key_clear}, 1);
        check("R5 policy 5 locks on glitch", {31'd0, locked}, 1);
        ev(5'b00100, 0);
        check("R7 wipe is one cycle", {31'd0, key_clear}, 0);
        rd(1);
        wr(2, 32'h1);
        check("R8 unlock at policy 5", {31'd0, locked}, 0);
    endtask

    task automatic t_same_cycle();
        wr(0, 32'h60);
        ev(5'b10000, 3'd1);
        check("R5 policy 3 locks on sw error", {31'd0, locked}, 1);
        rd(1);
        step(1, 0, 2, 32'h1, 5'b00001, 0);
        check("R8 event beats unlock", {31'd0, locked}, 1);
        step(0, 1, 1, 0, 5'b00100, 0);
        check("R10 read sees key-bus flag", rd_cap, 32'h01);
        rd(1); check("R10 event in read cycle survives", rd_cap, 32'h04);
        wr(2, 32'h1);
        check("R8 unlock after both cleared", {31'd0, locked}, 0);
    endtask

    task automatic t_seq();
        wr(0, 32'h40);
        ev(5'b01000, 0);
        check("R5 policy 2 locks on sequence", {31'd0, locked}, 1);
        wr(2, 32'h2);
        rd(1); check("R11 soft reset before read keeps flag", rd_cap, 32'h08);
        rd(1); check("R11 read alone keeps flag", rd_cap, 32'h08);
        wr(2, 32'h1);
        check("R11 unlock refused with sequence flag", {31'd0, locked}, 1);
        wr(2, 32'h2);
        rd(1); check("R11 read then soft reset clears", rd_cap, 0);
        wr(2, 32'h1);
        check("R8 unlock after sequence clear", {31'd0, locked}, 0);
    endtask

    task automatic t_first();
        wr(0, 32'h10);
        wr(9, 0); wr(13, 0);
        ev(5'b10000, 3'd3); ev(5'b10000, 3'd5);
        rd(1); check("R9 first-error capture", rd_cap, 32'h3912);
        wr(0, 32'h00);
        wr(9, 0); wr(13, 0);
        ev(5'b10000, 3'd3); ev(5'b10000, 3'd5);
        rd(1); check("R9 last-error capture", rd_cap, 32'h5D12);
        check("R4 policy 0 still unlocked", {31'd0, locked}, 0);
    endtask

    initial begin
        #(8 * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        ev_keybus = 0; ev_glitch = 0; ev_seq = 0; ev_swe = 0; swe_type = 0; start_req = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_key();
        t_block();
        t_report();
        t_group();
        t_wipe();
        t_same_cycle();
        t_seq();
        t_first();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule